// File: doc/BRIEF.md
# Bus Width and Endian Access Splitter

The splitter sits between an internal requester and an external memory bus whose width is chosen per request: 8, 16, 32 or 64 bits. A request carries a byte, word, longword, quadword or 32-byte block transfer. When the access is wider than the bus, the splitter issues a back-to-back train of external cycles and advances the address by the bus width on each one. It places every byte on the correct bus lane and packs read bytes into one result.

Byte order is fixed at reset from a mode input. It decides which end of a value lives at the lowest address, and it also decides which physical lane carries each address offset inside the bus word. A 32-byte block transfer starts with the requested 8-byte-aligned chunk. It then wraps around inside its aligned 32-byte block. The bus is not released between the cycles of one request.

A misaligned request or an unknown size code is refused. The splitter reports an error and issues no bus cycle. Only one request is in flight at a time, and completion is a single-cycle pulse that comes with the assembled read data.

Top module: `busSplitter`

## Requirements
- R1: While `rstN` is low, `modePin` is sampled. Low selects big-endian and high selects little-endian. Changes on `modePin` after reset has been released have no effect.
- R2: Request data is a numeric value whose byte v sits at `reqWdata[8v+7:8v]` (byte 0 is least significant), and the same holds for `rdData`. In little-endian mode value byte k is stored at address `reqAddr+k`. In big-endian mode value byte N-1-k is stored there, where N is the access size in bytes.
- R3: `reqSize` codes 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 32 bytes. `busWidth` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. A request takes max(1, N/W) cycles, where W is the bus width in bytes.
- R4: For sizes 0 to 3, cycle i is issued at address `reqAddr + i*min(N,W)`.
- R5: A 32-byte block transfer needs `reqAddr` aligned to 8. Cycle i is issued at `base + ((reqAddr mod 32) + i*W) mod 32`, where `base` is `reqAddr` with its low five bits cleared. Data byte k of the request or result is the byte at `base+k`, in either endian mode.
- R6: Lane L is `cycWdata[8L+7:8L]` / `cycRdata[8L+7:8L]`. In little-endian mode the byte at offset o inside the bus word uses lane o. In big-endian mode it uses lane W-1-o. Only the lanes of the bytes being moved are enabled in `cycLanes`.
- R7: `cycValid` stays high from the first cycle of a request until its last handshake, with no gap. While `cycReady` is low, `cycAddr` and `cycLanes` hold their values.
- R8: A request that is not aligned to its size, or that has size code 5 to 7, is accepted and issues no cycle. In the next cycle `done` and `doneErr` are both high.
- R9: `reqReady` is high only when no transfer is active. `done` pulses for one cycle, in the cycle after the final handshake. With that pulse, `rdData` holds the assembled read value, and its bytes beyond the access size are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; the endian mode is sampled while it is low |
| modePin | input | 1 | Endian select: 0 big, 1 little |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Splitter idle and accepting |
| reqAddr | input | ADDR_W | Request byte address |
| reqSize | input | 3 | Access size code |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | 256 | Write value or 32-byte block |
| busWidth | input | 2 | External bus width code, sampled at acceptance |
| cycValid | output | 1 | External cycle active |
| cycReady | input | 1 | External cycle completes this clock |
| cycAddr | output | ADDR_W | Byte address of the current cycle |
| cycWrite | output | 1 | Direction of the current cycle |
| cycLanes | output | 8 | Byte-lane enables |
| cycWdata | output | 64 | Write data on the lanes |
| cycRdata | input | 64 | Read data from the lanes |
| done | output | 1 | Request completed, one-cycle pulse |
| doneErr | output | 1 | Request refused, qualifies done |
| rdData | output | 256 | Assembled read value |

## Verification
A wrong cycle index or a wrong latched bus width shows up at once. `cycAddr` goes off the expected stepping or wrap order in the same cycle, and the cycle count seen before `done` comes out too high or too low. A wrong endian bit or a wrong lane map puts bytes on mirrored lanes. For writes this is visible in the cycle that carries them. For reads it appears as permuted bytes in `rdData` when `done` pulses. A state machine stuck in or out of the active state shows as `cycValid` dropping early, `reqReady` rising during a transfer, or `done` missing after the last handshake.

// File: rtl/splitPkg.sv
package splitPkg;
  localparam int BLK_BYTES = 32;
  localparam int BUS_BYTES = 8;
  localparam int BLK_W     = BLK_BYTES * 8;
  localparam int BUS_W     = BUS_BYTES * 8;
  localparam int IDX_W     = $clog2(BLK_BYTES);
  localparam int LANE_W    = $clog2(BUS_BYTES);

  localparam logic [2:0] SZ_BLOCK = 3'd4;

  typedef struct packed {
    logic             load;
    logic             step;
    logic [IDX_W-1:0] idx;
  } strobeT;

  function automatic logic [2:0] accLog2(input logic [2:0] sz);
    return (sz == SZ_BLOCK) ? 3'(IDX_W) : sz;
  endfunction

  function automatic logic [2:0] chunkLog2(input logic [2:0] sz, input logic [1:0] w);
    logic [2:0] a;
    a = accLog2(sz);
    return (a < {1'b0, w}) ? a : {1'b0, w};
  endfunction

  function automatic logic badReq(input logic [2:0] sz, input logic [IDX_W-1:0] lo);
    case (sz)
      3'd0:       return 1'b0;
      3'd1:       return lo[0];
      3'd2:       return |lo[1:0];
      3'd3, 3'd4: return |lo[2:0];
      default:    return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/splitCtrl.sv
module splitCtrl
  import splitPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqSize,
  input  logic [IDX_W-1:0] reqAddrLo,
  input  logic [1:0]       busWidth,
  input  logic             cycReady,
  output logic             reqReady,
  output logic             cycValid,
  output logic             done,
  output logic             doneErr,
  output strobeT           strb
);
  typedef enum logic {ST_IDLE, ST_RUN} stateT;

  stateT            state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic             accept;
  logic             bad;
  logic [2:0]       nLog2;

  assign accept = reqValid && (state == ST_IDLE);
  assign bad    = badReq(reqSize, reqAddrLo);
  assign nLog2  = accLog2(reqSize) - chunkLog2(reqSize, busWidth);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      lastIdx <= '0;
      done    <= 1'b0;
      doneErr <= 1'b0;
    end else begin
      done    <= 1'b0;
      doneErr <= 1'b0;
      if (accept) begin
        idx <= '0;
        if (bad) begin
          done    <= 1'b1;
          doneErr <= 1'b1;
        end else begin
          state   <= ST_RUN;
          lastIdx <= IDX_W'(((IDX_W+1)'(1) << nLog2) - (IDX_W+1)'(1));
        end
      end else if (state == ST_RUN && cycReady) begin
        if (idx == lastIdx) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign cycValid  = (state == ST_RUN);
  assign strb.load = accept;
  assign strb.step = (state == ST_RUN) && cycReady;
  assign strb.idx  = idx;
endmodule

// File: rtl/splitData.sv
module splitData
  import splitPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modePin,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              reqWrite,
  input  logic [BLK_W-1:0]  reqWdata,
  input  logic [1:0]        busWidth,
  input  logic [BUS_W-1:0]  cycRdata,
  output logic [ADDR_W-1:0] cycAddr,
  output logic              cycWrite,
  output logic [BUS_BYTES-1:0] cycLanes,
  output logic [BUS_W-1:0]  cycWdata,
  output logic [BLK_W-1:0]  rdData
);
  logic              bigEnd;
  logic [ADDR_W-1:0] aReg;
  logic [2:0]        sReg;
  logic [1:0]        wReg;
  logic              wrReg;
  logic [BLK_W-1:0]  wdReg;

  logic [2:0]        chL;
  logic [IDX_W-1:0]  relOff;
  logic [IDX_W-1:0]  accMax;
  logic [LANE_W-1:0] busMask;
  logic [LANE_W:0]   chunkBytes;
  logic              isBlock;
  logic [LANE_W-1:0] laneIdx [BUS_BYTES];
  logic [IDX_W-1:0]  valIdx  [BUS_BYTES];
  logic              byteOn  [BUS_BYTES];

  // endian mode: sampled on every edge while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) bigEnd <= !modePin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg  <= '0;
      sReg  <= '0;
      wReg  <= '0;
      wrReg <= 1'b0;
      wdReg <= '0;
    end else if (strb.load) begin
      aReg  <= reqAddr;
      sReg  <= reqSize;
      wReg  <= busWidth;
      wrReg <= reqWrite;
      wdReg <= reqWdata;
    end
  end

  assign isBlock    = (sReg == SZ_BLOCK);
  assign chL        = chunkLog2(sReg, wReg);
  assign chunkBytes = (LANE_W+1)'(1) << chL;
  assign busMask    = LANE_W'(((LANE_W+1)'(1) << wReg) - (LANE_W+1)'(1));
  assign accMax     = IDX_W'(((IDX_W+1)'(1) << accLog2(sReg)) - (IDX_W+1)'(1));
  assign relOff     = IDX_W'(strb.idx << chL);
  assign cycAddr    = isBlock ? {aReg[ADDR_W-1:IDX_W], IDX_W'(aReg[IDX_W-1:0] + relOff)}
                              : aReg + ADDR_W'(relOff);
  assign cycWrite   = wrReg;

  always_comb begin
    cycLanes = '0;
    cycWdata = '0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      logic [LANE_W-1:0] off;
      logic [IDX_W-1:0]  k;
      off        = LANE_W'(cycAddr[LANE_W-1:0] + LANE_W'(j)) & busMask;
      k          = isBlock ? IDX_W'(cycAddr[IDX_W-1:0] + IDX_W'(j)) : IDX_W'(relOff + IDX_W'(j));
      byteOn[j]  = (LANE_W+1)'(j) < chunkBytes;
      laneIdx[j] = bigEnd ? LANE_W'(busMask - off) : off;
      valIdx[j]  = (bigEnd && !isBlock) ? IDX_W'(accMax - k) : k;
      if (byteOn[j]) begin
        cycLanes[laneIdx[j]] = 1'b1;
        if (wrReg) cycWdata[{laneIdx[j], 3'b000} +: 8] = wdReg[{valIdx[j], 3'b000} +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.load) begin
      rdData <= '0;
    end else if (strb.step && !wrReg) begin
      for (int j = 0; j < BUS_BYTES; j++) begin
        if (byteOn[j]) rdData[{valIdx[j], 3'b000} +: 8] <= cycRdata[{laneIdx[j], 3'b000} +: 8];
      end
    end
  end
endmodule

// File: rtl/busSplitter.sv
module busSplitter
  import splitPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modePin,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              reqWrite,
  input  logic [255:0]      reqWdata,
  input  logic [1:0]        busWidth,
  output logic              cycValid,
  input  logic              cycReady,
  output logic [ADDR_W-1:0] cycAddr,
  output logic              cycWrite,
  output logic [7:0]        cycLanes,
  output logic [63:0]       cycWdata,
  input  logic [63:0]       cycRdata,
  output logic              done,
  output logic              doneErr,
  output logic [255:0]      rdData
);
  strobeT strb;

  splitCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSize(reqSize),
    .reqAddrLo(reqAddr[IDX_W-1:0]), .busWidth(busWidth), .cycReady(cycReady),
    .reqReady(reqReady), .cycValid(cycValid), .done(done), .doneErr(doneErr),
    .strb(strb)
  );

  splitData #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .modePin(modePin), .strb(strb), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqWdata(reqWdata), .busWidth(busWidth),
    .cycRdata(cycRdata), .cycAddr(cycAddr), .cycWrite(cycWrite), .cycLanes(cycLanes),
    .cycWdata(cycWdata), .rdData(rdData)
  );
endmodule

// File: rtl/splitChk.sv
module splitChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [2:0]        reqSize,
  input logic              cycValid,
  input logic              cycReady,
  input logic [ADDR_W-1:0] cycAddr,
  input logic [7:0]        cycLanes,
  input logic              done,
  input logic              doneErr
);
  assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cycValid) |-> done);

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    cycValid && !cycReady |=> cycValid && $stable(cycAddr) && $stable(cycLanes));

  assert_bad_size_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && (reqSize > 3'd4) |=> done && doneErr);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |-> !reqReady);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !cycValid && reqReady);

  assert_lanes_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |-> cycLanes != 8'h00);
endmodule

bind busSplitter splitChk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqSize(reqSize), .cycValid(cycValid), .cycReady(cycReady), .cycAddr(cycAddr),
  .cycLanes(cycLanes), .done(done), .doneErr(doneErr)
);

// File: tb/tb_busSplitter.sv
module tb_busSplitter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modePin = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [255:0] reqWdata = '0;
  logic [1:0]  busWidth = '0;
  logic        cycValid;
  logic        cycReady = 1'b1;
  logic [31:0] cycAddr;
  logic        cycWrite;
  logic [7:0]  cycLanes;
  logic [63:0] cycWdata;
  logic [63:0] cycRdata;
  logic        done, doneErr;
  logic [255:0] rdData;

  busSplitter dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycCount = 0;
  bit expBig = 1'b0;
  int tbW = 1;
  logic [7:0] mem [256];
  logic [255:0] wdPat;
  int nCyc;
  bit gotErr, gotDone, contFail, stabFail;
  logic [255:0] gotRd;
  int logAddr [64];
  logic [7:0] logLanes [64];

  // {write, size, width, addr}
  localparam logic [13:0] VEC [12] = '{
    {1'b0, 3'd0, 2'd0, 8'h13}, {1'b0, 3'd1, 2'd0, 8'h22}, {1'b0, 3'd2, 2'd0, 8'h40},
    {1'b1, 3'd2, 2'd1, 8'h44}, {1'b0, 3'd3, 2'd2, 8'h48}, {1'b1, 3'd3, 2'd0, 8'h58},
    {1'b0, 3'd2, 2'd3, 8'h64}, {1'b1, 3'd0, 2'd3, 8'h35}, {1'b0, 3'd4, 2'd3, 8'h90},
    {1'b1, 3'd4, 2'd2, 8'hB8}, {1'b0, 3'd4, 2'd0, 8'hC8}, {1'b1, 3'd1, 2'd2, 8'hE6}
  };

  function automatic logic [7:0] initByte(input int i);
    return 8'(((i & 255) * 13 + 5) ^ 8'h5A);
  endfunction

  always_comb begin
    cycRdata = '0;
    for (int l = 0; l < 8; l++) begin
      if (l < tbW)
        cycRdata[l*8 +: 8] = mem[8'((int'(cycAddr[7:0]) & ~(tbW-1)) + (expBig ? tbW-1-l : l))];
    end
  end

  always @(posedge clk) begin
    cycCount++;
    if (cycValid && cycReady && cycWrite) begin
      for (int l = 0; l < 8; l++) begin
        if (l < tbW && cycLanes[l])
          mem[8'((int'(cycAddr[7:0]) & ~(tbW-1)) + (expBig ? tbW-1-l : l))] = cycWdata[l*8 +: 8];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runReq(input bit wr, input int sz, input int wc, input int a, input bit stall);
    int prevA;
    logic [7:0] prevL;
    bit prevStall, started;
    int iter;
    tbW = 1 << wc;
    for (int i = 0; i < 256; i++) mem[i] = initByte(i);
    nCyc = 0; gotErr = 0; gotDone = 0; contFail = 0; stabFail = 0;
    prevStall = 0; started = 0; prevA = 0; prevL = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = 3'(sz); reqAddr = 32'(a);
    busWidth = 2'(wc); reqWdata = wdPat;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (iter = 0; iter < 200; iter++) begin
      if (done) begin
        gotDone = 1; gotErr = doneErr; gotRd = rdData;
        break;
      end
      if (started && !cycValid) contFail = 1;
      if (prevStall && (int'(cycAddr) != prevA || cycLanes != prevL)) stabFail = 1;
      cycReady = stall ? (iter % 3 == 2) : 1'b1;
      if (cycValid) started = 1;
      if (cycValid && cycReady && nCyc < 64) begin
        logAddr[nCyc] = int'(cycAddr);
        logLanes[nCyc] = cycLanes;
        nCyc++;
      end
      prevStall = cycValid && !cycReady;
      prevA = int'(cycAddr);
      prevL = cycLanes;
      @(negedge clk);
    end
    cycReady = 1'b1;
    check(gotDone, "R9 done after request", 0, 1);
  endtask

  task automatic checkRun(input bit wr, input int sz, input int wc, input int a);
    int n, w, ch, base, expCyc;
    bit addrOk, laneOk, dataOk;
    w = 1 << wc;
    n = (sz == 4) ? 32 : (1 << sz);
    ch = (n < w) ? n : w;
    base = a & ~31;
    expCyc = n / ch;
    check(nCyc == expCyc && !gotErr, "R3 cycle count", nCyc, expCyc);
    addrOk = 1; laneOk = 1;
    for (int i = 0; i < nCyc && i < 64; i++) begin
      int ea;
      logic [7:0] el;
      ea = (sz == 4) ? base + (((a & 31) + i * ch) & 31) : a + i * ch;
      el = '0;
      for (int j = 0; j < ch; j++) begin
        int o;
        o = (ea + j) & (w - 1);
        el[expBig ? w - 1 - o : o] = 1'b1;
      end
      if (logAddr[i] != ea) addrOk = 0;
      if (logLanes[i] != el) laneOk = 0;
    end
    if (sz == 4) check(addrOk, "R5 block cycle order", logAddr[0], a);
    else         check(addrOk, "R4 address stepping", logAddr[0], a);
    check(laneOk, "R6 lane enables", logLanes[0], 0);
    check(!contFail && !stabFail, "R7 continuous and held", {contFail, stabFail}, 0);
    dataOk = 1;
    if (wr) begin
      for (int k = 0; k < n; k++) begin
        int v;
        v = (sz == 4) ? k : (expBig ? n - 1 - k : k);
        if (sz == 4) begin
          if (mem[8'(base + k)] != wdPat[v*8 +: 8]) dataOk = 0;
        end else if (mem[8'(a + k)] != wdPat[v*8 +: 8]) dataOk = 0;
      end
      if (sz != 4 && mem[8'(a + n)] != initByte(a + n)) dataOk = 0;
    end else begin
      for (int v = 0; v < 32; v++) begin
        logic [7:0] e;
        if (sz == 4) e = initByte(base + v);
        else if (v < n) e = initByte(a + (expBig ? n - 1 - v : v));
        else e = 8'h00;
        if (gotRd[v*8 +: 8] != e) dataOk = 0;
      end
    end
    if (sz == 4) check(dataOk, "R5 block data", gotRd[63:0], 0);
    else check(dataOk, "R2 byte placement", gotRd[63:0], 0);
  endtask

  task automatic tableWalk(input bit stallOdd);
    for (int i = 0; i < 12; i++) begin
      logic [13:0] e;
      e = VEC[i];
      runReq(e[13], int'(e[12:10]), int'(e[9:8]), int'(e[7:0]), stallOdd && i[0]);
      checkRun(e[13], int'(e[12:10]), int'(e[9:8]), int'(e[7:0]));
    end
  endtask

  task automatic errCase(input int sz, input int a);
    runReq(1'b0, sz, 2, a, 1'b0);
    check(gotErr && nCyc == 0, "R8 refused request", {gotErr, 8'(nCyc)}, 9'h100);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) wdPat[i*8 +: 8] = 8'(8'hC0 ^ (i * 3 + 1));
    modePin = 1'b1; expBig = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady && !cycValid && !done, "R9 reset state", {reqReady, cycValid, done}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !cycValid && !done, "R9 idle after reset", {reqReady, cycValid, done}, 3'b100);

    tableWalk(1'b0);
    errCase(2, 8'h42);
    errCase(5, 8'h40);
    errCase(4, 8'h84);
    errCase(1, 8'h21);

    // R1: pin change after reset must not alter byte order
    modePin = 1'b0;
    runReq(1'b0, 2, 0, 8'h40, 1'b0);
    checkRun(1'b0, 2, 0, 8'h40);
    check(gotRd[7:0] == initByte(8'h40), "R1 mode ignored after reset", gotRd[7:0], initByte(8'h40));

    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expBig = 1'b1;
    modePin = 1'b1;
    runReq(1'b0, 2, 0, 8'h40, 1'b0);
    checkRun(1'b0, 2, 0, 8'h40);
    check(gotRd[7:0] == initByte(8'h43), "R1 big-endian latched", gotRd[7:0], initByte(8'h43));

    tableWalk(1'b1);
    errCase(3, 8'h4C);
    errCase(7, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycCount > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycCount, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule